// File: doc/BRIEF.md
# Register-Programmed Serial Word Master

This block is a serial-peripheral master that a host drives through a small 32-bit register port. The host sets up the bit clock, the per-device signalling mode and a data word. It then writes a command, and each accepted command moves exactly one word of 8 to 32 bits, most significant bit first. The serial clock is derived from the functional clock through a programmable divider. Clock polarity, clock phase, select polarity and a start delay are held separately for each of four select lines.

A select line is asserted at the first word of a frame and stays asserted between words. It is released on its own once the word count given in the command has been moved, or at once when a release command is written. The host finds out that a word has finished by polling a status register. It reads a received word back from the data register, right-aligned.

Register word addresses on `reg_addr`: 0 clock control, 1 device modes, 2 command, 3 status, 4 data.

Top module: `spi_word_engine`

## Requirements
- R1: Clock control (address 0) holds an enable in bit 31 and a divider in bits 15:0. Device modes (address 1) holds one byte per select line n at bits 8n+7:8n. Both read back as written.
- R2: While a word moves, the serial clock period is divider+1 functional-clock cycles. A divider of 0 behaves as 1.
- R3: Bit 0 of a line's mode byte gives the serial clock idle level. Bit 2 selects phase: 0 samples on the first edge of each bit, 1 samples on the second edge.
- R4: Bit 1 of a line's mode byte gives the select polarity (1 = active high). Every line that is not selected sits at the opposite level. Out of reset all lines are at the inactive-low-polarity level, so `cs_o` = 4'hF.
- R5: In the command word, bits 18:16 are the operation (1 read a word, 2 write a word, 4 release), bits 29:28 pick the select line, bits 11:0 give the frame length and bits 25:19 give word bits minus one. Word lengths are clamped to the range 8..32, and any other operation code is ignored.
- R6: A write shifts out the low word-length bits of the data register, most significant bit first.
- R7: A read holds `mosi_o` low and places the received bits right-aligned in the data register, with the upper bits zero.
- R8: Status bit 0 is busy and bit 1 is word-complete. Word-complete rises as busy falls. It clears on the next accepted command or after a status read, and it is never set together with busy.
- R9: A command written while busy is ignored. It moves no extra word and does not change the select lines.
- R10: The select stays asserted between words. It deasserts after the frame's word count completes, where a length of 0 or 1 means one word. At most one line is active at a time.
- R11: A release command deasserts the active select by the second cycle after it is written.
- R12: With the clock enable clear, a transfer stalls with busy held and the serial clock at its idle level. It resumes once the enable is set again.
- R13: Bits 4:3 of a line's mode byte delay the first serial clock edge of each word by that many clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears the next cycle |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |
| cs_o | output | 4 | Select lines, polarity per line |

## Verification
The bench builds the block with its default parameters: a 16-bit divider, four select lines and a 12-bit frame length. It then programs small dividers of 0 to 20 so that each word completes in tens to a few hundred cycles. These values reach the divider clamp, odd and even periods, both word-length clamps, the longest 32-bit word, and every select line with both polarities, both phases and a nonzero start delay. A 12-bit frame count also lets a frame be held open long enough to test release and busy-time commands.

// File: rtl/spi_we_pkg.sv
package spi_we_pkg;
  localparam int DATA_W = 32;
  localparam logic [2:0] A_CLK  = 3'd0;
  localparam logic [2:0] A_DEV  = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] OP_READ  = 3'd1;
  localparam logic [2:0] OP_WRITE = 3'd2;
  localparam logic [2:0] OP_INVAL = 3'd4;

  // effective word length from the (bits-1) field, clamped to 8..32
  function automatic logic [5:0] word_bits(input logic [6:0] f);
    int n;
    n = int'(f) + 1;
    if (n < 8) n = 8;
    if (n > 32) n = 32;
    return 6'(n);
  endfunction
endpackage

// File: rtl/spi_we_timer.sv
module spi_we_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       delay,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 3;

  logic [DIV_W:0]   period, half_a, half_b;
  logic [CNT_W-1:0] cnt, start_val;
  logic             odd;

  always_comb begin
    period    = (div == '0) ? (DIV_W+1)'(2) : ({1'b0, div} + (DIV_W+1)'(1));
    half_b    = period >> 1;
    half_a    = period - half_b;
    start_val = CNT_W'(half_a) + CNT_W'(delay) * CNT_W'(period);
  end

  assign tick = run && en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      odd <= 1'b0;
    end else if (start) begin
      cnt <= start_val;
      odd <= 1'b0;
    end else if (tick) begin
      cnt <= odd ? CNT_W'(half_a - 1'b1) : CNT_W'(half_b - 1'b1);
      odd <= ~odd;
    end else if (run && en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/spi_we_shift.sv
module spi_we_shift #(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        tick,
  input  logic                        en,
  input  logic                        cpol_idle,
  input  logic                        cpol_in,
  input  logic                        cpha_in,
  input  logic [$clog2(DATA_W):0]     nbits,
  input  logic                        is_read,
  input  logic [DATA_W-1:0]           tx_word,
  input  logic                        miso,
  output logic                        busy,
  output logic                        done,
  output logic                        sclk,
  output logic                        mosi,
  output logic [DATA_W-1:0]           rx_word
);
  localparam int BW = $clog2(DATA_W) + 1;
  localparam int EW = BW + 1;

  logic [DATA_W-1:0] tx_sr, rx_sr, aligned;
  logic [BW-1:0]     bits_q;
  logic [EW-1:0]     e, last_e;
  logic              cpol_q, cpha_q;

  assign aligned = is_read ? '0 : (tx_word << (DATA_W - int'(nbits)));
  assign last_e  = EW'({bits_q, 1'b0}) - EW'(1);
  assign rx_word = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; sclk <= 1'b0; mosi <= 1'b0;
      e <= '0; tx_sr <= '0; rx_sr <= '0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; bits_q <= BW'(8);
    end else begin
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        e      <= '0;
        cpol_q <= cpol_in;
        cpha_q <= cpha_in;
        bits_q <= nbits;
        rx_sr  <= '0;
        sclk   <= cpol_in;
        if (cpha_in) begin
          tx_sr <= aligned;
          mosi  <= 1'b0;
        end else begin
          tx_sr <= aligned << 1;
          mosi  <= aligned[DATA_W-1];
        end
      end else if (busy) begin
        if (!en) begin
          sclk <= cpol_q;
        end else if (tick) begin
          sclk <= e[0] ? cpol_q : ~cpol_q;
          if (e[0] == cpha_q) begin
            rx_sr <= {rx_sr[DATA_W-2:0], miso};
          end else if (e != last_e) begin
            mosi  <= tx_sr[DATA_W-1];
            tx_sr <= tx_sr << 1;
          end
          if (e == last_e) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          e <= e + 1'b1;
        end
      end else begin
        sclk <= cpol_idle;
      end
    end
  end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_we_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int NUM_CS = 4,
  parameter int FLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int BW   = $clog2(DATA_W) + 1;

  logic              clk_en_q, wc_q, frame_act, rd_q;
  logic [DIV_W-1:0]  div_q;
  logic [31:0]       dev_q, cmd_q, data_q;
  logic [CS_W-1:0]   cs_sel, cs_new, cs_use;
  logic [FLEN_W-1:0] remain, flen;
  logic [2:0]        op;
  logic              cmd_hit, go, inval, eng_busy;
  logic              sh_busy, sh_done, tick;
  logic [DATA_W-1:0] rx_word;
  logic [BW-1:0]     nbits;
  logic [NUM_CS-1:0] cpol_v, cspol_v, cpha_v, cs_nxt, cs_pol_vec;
  logic [1:0]        dd_v [NUM_CS];

  genvar g;
  generate
    for (g = 0; g < NUM_CS; g++) begin : g_line
      assign cpol_v[g]  = dev_q[8*g];
      assign cspol_v[g] = dev_q[8*g+1];
      assign cpha_v[g]  = dev_q[8*g+2];
      assign dd_v[g]    = dev_q[8*g+3 +: 2];
      assign cs_nxt[g]  = (frame_act && cs_sel == CS_W'(g)) ? cspol_v[g] : ~cspol_v[g];
    end
  endgenerate
  assign cs_pol_vec = cspol_v;

  assign op       = reg_wdata[18:16];
  assign flen     = reg_wdata[FLEN_W-1:0];
  assign cs_new   = reg_wdata[28 +: CS_W];
  assign nbits    = BW'(word_bits(reg_wdata[25:19]));
  assign eng_busy = sh_busy | sh_done;
  assign cmd_hit  = reg_wr && (reg_addr == A_CMD) && !eng_busy;
  assign go       = cmd_hit && (op == OP_READ || op == OP_WRITE);
  assign inval    = cmd_hit && (op == OP_INVAL);
  assign cs_use   = frame_act ? cs_sel : cs_new;

  spi_we_timer #(.DIV_W(DIV_W)) timer_i (
    .clk(clk), .rst(rst), .start(go), .run(sh_busy), .en(clk_en_q),
    .div(div_q), .delay(dd_v[cs_use]), .tick(tick)
  );

  spi_we_shift #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .start(go), .tick(tick), .en(clk_en_q),
    .cpol_idle(cpol_v[cs_sel]), .cpol_in(cpol_v[cs_use]), .cpha_in(cpha_v[cs_use]),
    .nbits(nbits), .is_read(op == OP_READ), .tx_word(data_q), .miso(miso_i),
    .busy(sh_busy), .done(sh_done), .sclk(sclk_o), .mosi(mosi_o), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en_q <= 1'b0; div_q <= '0; dev_q <= '0; cmd_q <= '0; data_q <= '0;
      wc_q <= 1'b0; frame_act <= 1'b0; rd_q <= 1'b0; cs_sel <= '0; remain <= '0;
      reg_rdata <= '0; cs_o <= '1;
    end else begin
      cs_o <= cs_nxt;
      if (reg_wr) begin
        case (reg_addr)
          A_CLK:  begin clk_en_q <= reg_wdata[31]; div_q <= reg_wdata[DIV_W-1:0]; end
          A_DEV:  dev_q  <= reg_wdata;
          A_DATA: data_q <= reg_wdata;
          default: ;
        endcase
      end
      if (go || inval) begin
        cmd_q <= reg_wdata;
        wc_q  <= 1'b0;
      end else if (reg_rd && reg_addr == A_STAT) begin
        wc_q <= 1'b0;
      end
      if (go) begin
        rd_q <= (op == OP_READ);
        if (!frame_act) begin
          frame_act <= 1'b1;
          cs_sel    <= cs_new;
          remain    <= (flen == '0) ? '0 : flen - 1'b1;
        end
      end
      if (inval) frame_act <= 1'b0;
      if (sh_done) begin
        wc_q <= 1'b1;
        if (rd_q) data_q <= rx_word;
        if (remain == '0) frame_act <= 1'b0;
        else              remain    <= remain - 1'b1;
      end
      if (reg_rd) begin
        case (reg_addr)
          A_CLK:   reg_rdata <= {clk_en_q, {(31-DIV_W){1'b0}}, div_q};
          A_DEV:   reg_rdata <= dev_q;
          A_CMD:   reg_rdata <= cmd_q;
          A_STAT:  reg_rdata <= {30'd0, wc_q, eng_busy};
          A_DATA:  reg_rdata <= data_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_we_checker.sv
module spi_we_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wc,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [NUM_CS-1:0] cs_o,
  input logic [NUM_CS-1:0] cs_pol,
  input logic              sclk,
  input logic              clk_en
);
  // R8: word-complete and busy are exclusive
  p_busy_wc_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && wc));

  // R8: word-complete only rises as busy drops
  p_wc_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wc) |-> $fell(busy));

  // R10: at most one select line active
  p_one_cs_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~(cs_o ^ $past(cs_pol))));

  // R9: a command written while busy leaves the select lines alone
  p_cs_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_addr == 3'd2) |=> $stable(cs_o));

  // R12: serial clock frozen while disabled mid-word
  p_sclk_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && $past(!clk_en) && busy && $past(busy)) |-> $stable(sclk));
endmodule

bind spi_word_engine spi_we_checker #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst(rst), .busy(eng_busy), .wc(wc_q), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .cs_o(cs_o), .cs_pol(cs_pol_vec), .sclk(sclk_o),
  .clk_en(clk_en_q)
);

// File: tb/spi_word_engine_tb_top.sv
`timescale 1ns/1ps
module spi_word_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk_o, mosi_o, miso_i;
  logic [3:0]  cs_o;

  always #2 clk = ~clk;

  spi_word_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .cs_o(cs_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  // device model state
  int          m_cs = 0, m_bits = 8, bidx = 0, ecnt = 0, t_lead0 = -1, t_lead1 = -1, t_cmd = 0;
  logic        m_pol = 1'b0, m_cpha = 1'b0, m_arm = 1'b0, prev_sclk = 1'b0;
  logic [31:0] s_tx = '0, s_rx = '0, dev_sh = '0;

  always @(negedge clk) begin
    if (m_arm) begin
      miso_i = m_cpha ? 1'b0 : s_tx[m_bits-1];
      m_arm  = 1'b0;
    end else if ((cs_o[m_cs] === m_pol) && (sclk_o !== prev_sclk)) begin
      if (ecnt % 2 == 0) begin
        if (ecnt == 0) t_lead0 = cyc;
        if (ecnt == 2) t_lead1 = cyc;
      end
      if ((ecnt % 2 == 0) != m_cpha) begin
        s_rx = {s_rx[30:0], mosi_o};
      end else if (m_cpha) begin
        if (bidx >= 0) miso_i = s_tx[bidx];
        bidx--;
      end else begin
        bidx--;
        if (bidx >= 0) miso_i = s_tx[bidx];
      end
      ecnt++;
    end
    prev_sclk = sclk_o;
  end

  function automatic logic [31:0] mask(input int bits);
    return (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [2:0] op, input int cs, input int wlf, input int flen);
    return {2'b00, 2'(cs), 2'b00, 7'(wlf), op, 4'b0000, 12'(flen)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_mode(input int cs, input logic cpol, input logic pol, input logic cpha, input int dd);
    dev_sh[8*cs +: 8] = {3'b000, 2'(dd), cpha, pol, cpol};
    reg_write(3'd1, dev_sh);
  endtask

  task automatic arm(input int cs, input logic pol, input logic cpha, input int bits, input logic [31:0] tx);
    m_cs = cs; m_pol = pol; m_cpha = cpha; m_bits = bits; s_tx = tx;
    bidx = bits - 1; ecnt = 0; s_rx = '0; t_lead0 = -1; t_lead1 = -1; m_arm = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input int cs, input int wlf, input int flen, input logic [31:0] d);
    if (op == 3'd2) reg_write(3'd4, d);
    reg_write(3'd2, mk_cmd(op, cs, wlf, flen));
    t_cmd = cyc;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      reg_read(3'd3, st);
      if (st[1:0] == 2'b10) return;
    end
    chk({tag, " completion timeout"}, st, 32'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d;
    int cs, bits, off0, off2;
    logic cpol, cpha, pol, isrd;
    void'($urandom(32'h5EED_0042));
    miso_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state (R4, R8)
    chk("R4 reset cs", {28'd0, cs_o}, 32'hF);
    chk("R3 reset sclk", {31'd0, sclk_o}, 32'd0);
    reg_read(3'd3, rd); chk("R8 reset status", rd, 32'd0);

    // R1 readback
    reg_write(3'd0, 32'h8000_0003);
    reg_read(3'd0, rd); chk("R1 clock readback", rd, 32'h8000_0003);
    set_mode(1, 1'b1, 1'b0, 1'b1, 1);
    reg_read(3'd1, rd); chk("R1 mode readback", rd, 32'h0000_0D00);
    dev_sh = '0; reg_write(3'd1, dev_sh);

    // R6 / R2: directed write, div 3 -> period 4
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h0000_01A5);
    wait_done("R6");
    chk("R6 write byte", s_rx, 32'hA5);
    chk("R2 period div3", 32'(t_lead1 - t_lead0), 32'd4);

    // R2: divider 0 acts as 1, odd divider 6
    reg_write(3'd0, 32'h8000_0000);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h3C);
    wait_done("R2");
    chk("R2 period div0", 32'(t_lead1 - t_lead0), 32'd2);
    reg_write(3'd0, 32'h8000_0006);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h3C);
    wait_done("R2");
    chk("R2 period div6", 32'(t_lead1 - t_lead0), 32'd7);

    // R7: directed read
    reg_write(3'd0, 32'h8000_0002);
    arm(0, 1'b0, 1'b0, 12, 32'h0000_0B6D);
    issue(3'd1, 0, 11, 0, '0);
    wait_done("R7");
    reg_read(3'd4, rd);
    chk("R7 read right aligned", rd, 32'h0000_0B6D);
    chk("R7 mosi low on read", s_rx, 32'd0);

    // R3/R5/R6/R7: random words across lines, modes and lengths
    for (int it = 0; it < 24; it++) begin
      cs = $urandom % 4; cpol = 1'($urandom); cpha = 1'($urandom); pol = 1'($urandom);
      bits = 8 + ($urandom % 25); isrd = 1'($urandom); d = $urandom;
      reg_write(3'd0, 32'h8000_0000 | (1 + $urandom % 4));
      set_mode(cs, cpol, pol, cpha, 0);
      arm(cs, pol, cpha, bits, d);
      issue(isrd ? 3'd1 : 3'd2, cs, bits - 1, 0, d);
      wait_done("R5");
      chk("R5 edge count", ecnt, 32'(2 * bits));
      if (isrd) begin
        reg_read(3'd4, rd);
        chk("R7 random read", rd, d & mask(bits));
      end else begin
        chk("R6 random write", s_rx, d & mask(bits));
      end
      @(negedge clk);
      chk("R3 idle level", {31'd0, sclk_o}, {31'd0, cpol});
      chk("R10 single-word frame released", {31'd0, cs_o[cs]}, {31'd0, ~pol});
      dev_sh = '0; reg_write(3'd1, dev_sh);
    end

    // R5: word length clamps
    reg_write(3'd0, 32'h8000_0001);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 2, 0, 32'hFFFF_FF96);
    wait_done("R5");
    chk("R5 short clamp edges", ecnt, 32'd16);
    chk("R5 short clamp data", s_rx, 32'h96);
    arm(0, 1'b0, 1'b0, 32, '0);
    issue(3'd2, 0, 45, 0, 32'hC001_D00D);
    wait_done("R5");
    chk("R5 long clamp data", s_rx, 32'hC001_D00D);

    // R5: unknown operation ignored
    arm(2, 1'b0, 1'b0, 8, '0);
    reg_write(3'd2, mk_cmd(3'd3, 2, 7, 0));
    repeat (20) @(negedge clk);
    chk("R5 bad op cs", {28'd0, cs_o}, 32'hF);
    chk("R5 bad op edges", ecnt, 32'd0);
    reg_read(3'd3, rd); chk("R5 bad op status", rd, 32'd0);

    // R8: word-complete clears on status read and on command write
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h11);
    repeat (60) @(negedge clk);
    reg_read(3'd3, rd); chk("R8 complete seen", rd, 32'd2);
    reg_read(3'd3, rd); chk("R8 cleared by read", rd, 32'd0);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h22);
    repeat (60) @(negedge clk);
    issue(3'd2, 0, 7, 0, 32'h33);
    reg_read(3'd3, rd); chk("R8 cleared by command", rd, 32'd1);
    wait_done("R8");

    // R10: frame of three words holds the select (R4 active-high on line 3)
    set_mode(3, 1'b0, 1'b1, 1'b0, 0);
    for (int w = 0; w < 3; w++) begin
      arm(3, 1'b1, 1'b0, 8, '0);
      issue(3'd2, 3, 7, 3, 32'h40 + w);
      wait_done("R10");
      @(negedge clk);
      chk("R6 frame word", s_rx, 32'h40 + w);
      chk("R10 select across words", {31'd0, cs_o[3]}, (w < 2) ? 32'd1 : 32'd0);
    end
    chk("R4 active-high released", {28'd0, cs_o}, 32'h7);

    // R9 and R11: busy commands ignored, then release
    reg_write(3'd0, 32'h8000_0014);
    arm(3, 1'b1, 1'b0, 8, '0);
    issue(3'd2, 3, 7, 5, 32'h5A);
    reg_write(3'd2, mk_cmd(3'd4, 3, 7, 0));
    reg_write(3'd2, mk_cmd(3'd2, 3, 7, 0));
    wait_done("R9");
    @(negedge clk);
    chk("R9 one word only", ecnt, 32'd16);
    chk("R9 select kept", {31'd0, cs_o[3]}, 32'd1);
    reg_write(3'd2, mk_cmd(3'd4, 3, 7, 0));
    @(negedge clk);
    chk("R11 release", {31'd0, cs_o[3]}, 32'd0);
    dev_sh = '0; reg_write(3'd1, dev_sh);

    // R12: disabled clock stalls with idle level
    set_mode(1, 1'b1, 1'b0, 1'b0, 0);
    reg_write(3'd0, 32'h0000_0002);
    arm(1, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 1, 7, 0, 32'hE7);
    repeat (40) @(negedge clk);
    chk("R12 sclk idle while off", {31'd0, sclk_o}, 32'd1);
    reg_read(3'd3, rd); chk("R12 busy while off", rd, 32'd1);
    chk("R12 no edges while off", ecnt, 32'd0);
    reg_write(3'd0, 32'h8000_0002);
    wait_done("R12");
    chk("R12 resumed data", s_rx, 32'hE7);
    @(negedge clk);
    chk("R3 idle high after frame", {31'd0, sclk_o}, 32'd1);
    dev_sh = '0; reg_write(3'd1, dev_sh);

    // R13: start delay of two periods (div 3 -> period 4)
    reg_write(3'd0, 32'h8000_0003);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h81);
    wait_done("R13");
    off0 = t_lead0 - t_cmd;
    set_mode(0, 1'b0, 1'b0, 1'b0, 2);
    arm(0, 1'b0, 1'b0, 8, '0);
    issue(3'd2, 0, 7, 0, 32'h81);
    wait_done("R13");
    off2 = t_lead0 - t_cmd;
    chk("R13 delay offset", 32'(off2 - off0), 32'd8);
    chk("R13 data intact", s_rx, 32'h81);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule